// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Slave

This block is the slave side of a two-wire serial memory with 1 Kbyte of storage, split into four blocks of 256 bytes. It watches an oversampled clock line and data line, finds START and STOP conditions, and decodes a select byte. That byte carries a fixed identifier, one strap-match bit, the two high address bits and the transfer direction. The block answers by pulling the data line low through an open-drain enable. It supports reads at the current address, reads at a random address and sequential reads of any length, as well as single-byte and burst writes.

Written bytes are collected in a small burst buffer. They reach the array only after STOP, during a programming window whose length is a parameter. While that window runs the slave ignores its select byte, so a bus master can poll with select bytes until it gets an acknowledge. A mode pin sets the burst size. With the pin high, a burst takes up to 8 bytes and the address climbs across the whole range. With the pin low, a burst takes up to 16 bytes and the address wraps inside a 16-byte page. A lock input refuses all data bytes.

Top module: `eeprom_i2c_slave`

## Requirements
- R1: The select byte (first bit on the wire = bit 7) is acknowledged only when bits 7..4 are 1010 and bit 3 equals `chip_sel_i`. Otherwise the slave stays silent until the next START, including the acknowledge slots of any later bytes.
- R2: After a write select byte (bit 0 = 0) and one low address byte, each data byte is acknowledged and later read back unchanged. The array is written only after STOP.
- R3: For PROG_CYCLES clocks after a STOP that ends a write with at least one accepted byte, select bytes are not acknowledged. After that window they are acknowledged again.
- R4: With `burst8_i` low, a write accepts up to 16 bytes. The address wraps within bits 3..0, so it stays inside the current 16-byte page. The 17th byte is not acknowledged and is discarded.
- R5: With `burst8_i` high, a write accepts up to 8 bytes and the address increments across the full 10-bit range. The 9th byte is not acknowledged. A single-byte write works in either mode.
- R6: A random read is built from a write select byte, a low address byte, a repeated START and a read select byte. It returns the byte at {select bits 2..1, low address}.
- R7: A current-address read returns the byte at {select bits 2..1, low 8 bits of the internal counter}. The counter points one past the last byte read or written.
- R8: A sequential read continues while the master acknowledges. The address increments after each byte and wraps from 1023 to 0.
- R9: After the master leaves a read byte unacknowledged, the slave releases the data line and drives nothing until STOP or START.
- R10: With `wr_lock_i` high, data bytes are not acknowledged, the array keeps its contents and no programming window starts.
- R11: Out of reset the data line is released and a matching select byte is acknowledged at once.
- R12: The open-drain enable changes only while the synchronised clock line is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oversampling system clock |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level (wired bus value) |
| sda_oe_o | output | 1 | 1 pulls the data line low |
| chip_sel_i | input | 1 | Strap level that select bit 3 must match |
| burst8_i | input | 1 | 1: 8-byte linear burst, 0: 16-byte page burst |
| wr_lock_i | input | 1 | 1 refuses all written data bytes |

## Verification
The bench builds the block with PROG_CYCLES = 300 and keeps the default burst sizes of 16 and 8. A 300-clock programming window is longer than one select byte at the bench's bit rate, so the first poll after a write lands inside the window and a later poll lands after it, which exercises both sides of R3. With the default page and linear sizes, a single burst can reach the page wrap at 0x3F5, the 8-byte limit across a page boundary, and the 1023-to-0 wrap of a sequential read.

// File: rtl/eeprom_pkg.sv
// Shared types and constants for the two-wire EEPROM slave.
// Assumes a select byte with 4 identifier bits, 1 strap bit, 2 block bits, 1 direction bit.
package eeprom_pkg;
    localparam int LOW_W = 8;
    localparam int BLK_W = 2;
    localparam int ADDR_W = LOW_W + BLK_W;
    localparam logic [3:0] DEV_ID = 4'b1010;

    typedef enum logic [2:0] {S_IDLE, S_RX, S_ACK, S_TX, S_RACK, S_WAIT} link_state_t;
    typedef enum logic [1:0] {K_DEV, K_ADDR, K_DATA} rx_kind_t;
endpackage

// File: rtl/bus_cond_detect.sv
// Synchronises the clock and data lines and flags clock edges, START and STOP.
// Assumes both lines idle high; outputs lag the pins by two clocks.
module bus_cond_detect (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_lvl_o,
    output logic sda_lvl_o,
    output logic scl_rise_o,
    output logic scl_fall_o,
    output logic start_o,
    output logic stop_o
);
    logic [1:0] meta_q, sync_q, prev_q;   // {scl, sda}

    // Two-stage synchroniser plus one history stage for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= 2'b11;
            sync_q <= 2'b11;
            prev_q <= 2'b11;
        end else begin
            meta_q <= {scl_i, sda_i};
            sync_q <= meta_q;
            prev_q <= sync_q;
        end
    end

    // Edge and bus-condition decode from current and previous samples
    always_comb begin
        scl_lvl_o  = sync_q[1];
        sda_lvl_o  = sync_q[0];
        scl_rise_o = sync_q[1] & ~prev_q[1];
        scl_fall_o = ~sync_q[1] & prev_q[1];
        start_o    = sync_q[1] & prev_q[1] & prev_q[0] & ~sync_q[0];
        stop_o     = sync_q[1] & prev_q[1] & ~prev_q[0] & sync_q[0];
    end
endmodule

// File: rtl/prog_timer.sv
// Models the self-timed programming window as a fixed count of clocks.
// Assumes kick arrives only while idle; step counts 0..CYCLES-1 while busy.
module prog_timer #(
    parameter int CYCLES = 5000,
    parameter int CW = $clog2(CYCLES + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          kick_i,
    output logic          busy_o,
    output logic [CW-1:0] step_o
);
    localparam logic [CW-1:0] LAST = CW'(CYCLES - 1);
    localparam logic [CW-1:0] ONE  = CW'(1);

    // Run the counter for CYCLES clocks after a kick
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_o <= 1'b0;
            step_o <= '0;
        end else if (busy_o) begin
            if (step_o == LAST) busy_o <= 1'b0;
            else                step_o <= step_o + ONE;
        end else if (kick_i) begin
            busy_o <= 1'b1;
            step_o <= '0;
        end
    end

    assert_step_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> (int'(step_o) < CYCLES));
endmodule

// File: rtl/byte_store.sv
// Byte-wide storage array with one write port and an asynchronous read port.
// Assumes contents are undefined until written; no reset on the array.
module byte_store #(
    parameter int AW = 10,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          we_i,
    input  logic [AW-1:0] waddr_i,
    input  logic [DW-1:0] wdata_i,
    input  logic [AW-1:0] raddr_i,
    output logic [DW-1:0] rdata_o
);
    localparam int DEPTH = 1 << AW;
    logic [DW-1:0] cells [DEPTH];

    // Single write port
    always_ff @(posedge clk) begin
        if (we_i) cells[waddr_i] <= wdata_i;
    end

    assign rdata_o = cells[raddr_i];
endmodule

// File: rtl/eeprom_i2c_slave.sv
// Two-wire serial EEPROM slave: select decode, address counter, burst buffer,
// read shifter, and commit of buffered bytes during the programming window.
// Assumes PAGE_BYTES is a power of two, MULTI_BYTES <= PAGE_BYTES, PROG_CYCLES >= PAGE_BYTES.
module eeprom_i2c_slave #(
    parameter int PAGE_BYTES  = 16,
    parameter int MULTI_BYTES = 8,
    parameter int PROG_CYCLES = 5000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_oe_o,
    input  logic chip_sel_i,
    input  logic burst8_i,
    input  logic wr_lock_i
);
    import eeprom_pkg::*;

    localparam int PAGE_W = $clog2(PAGE_BYTES);
    localparam int CNT_W  = PAGE_W + 1;
    localparam int STEP_W = $clog2(PROG_CYCLES + 1);
    localparam logic [ADDR_W-1:0] A_ONE = ADDR_W'(1);
    localparam logic [PAGE_W-1:0] P_ONE = PAGE_W'(1);
    localparam logic [CNT_W-1:0]  C_ONE = CNT_W'(1);

    logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
    logic busy, busy_q, prog_kick;
    logic [STEP_W-1:0] step;

    link_state_t state;
    rx_kind_t    kind;
    logic [7:0]  shreg;
    logic [3:0]  bitcnt;
    logic        rd_mode, mack;
    logic [ADDR_W-1:0] ptr;
    logic [CNT_W-1:0]  wcount;
    logic [ADDR_W-1:0] wb_addr [PAGE_BYTES];
    logic [7:0]        wb_data [PAGE_BYTES];

    logic              store_we;
    logic [PAGE_W-1:0] commit_idx;
    logic [7:0]        rdata;
    logic              dev_ok;
    int                limit;

    bus_cond_detect u_detect (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .scl_lvl_o(scl_s), .sda_lvl_o(sda_s), .scl_rise_o(scl_rise),
        .scl_fall_o(scl_fall), .start_o(start_det), .stop_o(stop_det)
    );

    prog_timer #(.CYCLES(PROG_CYCLES), .CW(STEP_W)) u_timer (
        .clk(clk), .rst_n(rst_n), .kick_i(prog_kick), .busy_o(busy), .step_o(step)
    );

    byte_store #(.AW(ADDR_W), .DW(8)) u_store (
        .clk(clk), .we_i(store_we), .waddr_i(wb_addr[commit_idx]),
        .wdata_i(wb_data[commit_idx]), .raddr_i(ptr), .rdata_o(rdata)
    );

    // Next write address: page wrap or linear increment
    function automatic logic [ADDR_W-1:0] next_wptr(input logic [ADDR_W-1:0] p, input logic linear);
        logic [PAGE_W-1:0] lo;
        lo = p[PAGE_W-1:0] + P_ONE;
        if (linear) return p + A_ONE;
        return {p[ADDR_W-1:PAGE_W], lo};
    endfunction

    // Commit one buffered byte per clock at the start of the window
    always_comb begin
        commit_idx = step[PAGE_W-1:0];
        store_we   = busy && (int'(step) < int'(wcount));
        prog_kick  = stop_det && (wcount != '0) && !busy;
        limit      = burst8_i ? MULTI_BYTES : PAGE_BYTES;
        dev_ok     = (shreg[7:4] == DEV_ID) && (shreg[3] == chip_sel_i) && !busy;
    end

    // Bus protocol state machine and burst buffer
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= S_IDLE;
            kind     <= K_DEV;
            shreg    <= '0;
            bitcnt   <= '0;
            rd_mode  <= 1'b0;
            mack     <= 1'b0;
            ptr      <= '0;
            wcount   <= '0;
            sda_oe_o <= 1'b0;
            busy_q   <= 1'b0;
        end else begin
            busy_q <= busy;
            if (busy_q && !busy) wcount <= '0;
            if (stop_det) begin
                state    <= S_IDLE;
                sda_oe_o <= 1'b0;
            end else if (start_det) begin
                state    <= S_RX;
                kind     <= K_DEV;
                bitcnt   <= '0;
                sda_oe_o <= 1'b0;
            end else begin
                case (state)
                    S_RX: begin
                        if (scl_rise && bitcnt != 4'd8) begin
                            shreg  <= {shreg[6:0], sda_s};
                            bitcnt <= bitcnt + 4'd1;
                        end else if (scl_fall && bitcnt == 4'd8) begin
                            case (kind)
                                K_DEV: begin
                                    if (dev_ok) begin
                                        sda_oe_o <= 1'b1;
                                        state    <= S_ACK;
                                        ptr[ADDR_W-1:LOW_W] <= shreg[2:1];
                                        rd_mode  <= shreg[0];
                                    end else begin
                                        state <= S_WAIT;
                                    end
                                end
                                K_ADDR: begin
                                    sda_oe_o <= 1'b1;
                                    state    <= S_ACK;
                                    ptr[LOW_W-1:0] <= shreg;
                                    wcount   <= '0;
                                end
                                default: begin
                                    if (!wr_lock_i && int'(wcount) < limit) begin
                                        sda_oe_o <= 1'b1;
                                        state    <= S_ACK;
                                        wb_addr[wcount[PAGE_W-1:0]] <= ptr;
                                        wb_data[wcount[PAGE_W-1:0]] <= shreg;
                                        wcount   <= wcount + C_ONE;
                                        ptr      <= next_wptr(ptr, burst8_i);
                                    end else begin
                                        state <= S_WAIT;
                                    end
                                end
                            endcase
                        end
                    end
                    S_ACK: begin
                        if (scl_fall) begin
                            if (kind == K_DEV && rd_mode) begin
                                shreg    <= rdata;
                                sda_oe_o <= ~rdata[7];
                                bitcnt   <= 4'd1;
                                state    <= S_TX;
                            end else begin
                                sda_oe_o <= 1'b0;
                                bitcnt   <= '0;
                                kind     <= (kind == K_DEV) ? K_ADDR : K_DATA;
                                state    <= S_RX;
                            end
                        end
                    end
                    S_TX: begin
                        if (scl_fall) begin
                            if (bitcnt != 4'd8) begin
                                sda_oe_o <= ~shreg[6];
                                shreg    <= {shreg[6:0], 1'b0};
                                bitcnt   <= bitcnt + 4'd1;
                            end else begin
                                sda_oe_o <= 1'b0;
                                ptr      <= ptr + A_ONE;
                                state    <= S_RACK;
                            end
                        end
                    end
                    S_RACK: begin
                        if (scl_rise) mack <= ~sda_s;
                        if (scl_fall) begin
                            if (mack) begin
                                shreg    <= rdata;
                                sda_oe_o <= ~rdata[7];
                                bitcnt   <= 4'd1;
                                state    <= S_TX;
                            end else begin
                                state <= S_WAIT;
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    assert_sda_scl_low_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe_o) |-> !scl_s);
    assert_busy_nack_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && state == S_RX && kind == K_DEV && scl_fall && bitcnt == 4'd8 && !start_det && !stop_det)
        |=> !sda_oe_o);
    assert_burst_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
        int'(wcount) <= PAGE_BYTES);
    assert_prog_after_stop_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(stop_det));
    assert_wait_silent_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_WAIT) |-> !sda_oe_o);
    assert_lock_nack_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_lock_i && state == S_RX && kind == K_DATA && scl_fall && bitcnt == 4'd8 && !start_det && !stop_det)
        |=> (!sda_oe_o && state == S_WAIT));
endmodule

// File: tb/test_eeprom_i2c_slave.sv
// Bit-banged bus master with a reference array; directed corners plus seeded random bursts.
module test_eeprom_i2c_slave;
    localparam int PROG  = 300;
    localparam int Q     = 4;
    localparam int WATCH = 190000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic m_scl = 1'b1;
    logic m_sda = 1'b1;
    logic cs_pin = 1'b1;
    logic burst8 = 1'b0;
    logic lock = 1'b0;
    logic sda_oe;
    logic bus_sda;

    assign bus_sda = m_sda & ~sda_oe;
    always #2 clk = ~clk;

    eeprom_i2c_slave #(.PROG_CYCLES(PROG)) i_eeprom_i2c_slave (
        .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(bus_sda), .sda_oe_o(sda_oe),
        .chip_sel_i(cs_pin), .burst8_i(burst8), .wr_lock_i(lock)
    );

    int n_chk = 0;
    int n_fail = 0;
    logic [7:0] ref_mem [1024];
    bit         ref_ok [1024];
    int         ref_ptr = 0;
    logic [7:0] wdat [20];

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wq();
        repeat (Q) @(negedge clk);
    endtask

    task automatic bus_start();
        m_sda = 1'b1; wq(); m_scl = 1'b1; wq(); m_sda = 1'b0; wq(); m_scl = 1'b0; wq();
    endtask

    task automatic bus_stop();
        m_sda = 1'b0; wq(); m_scl = 1'b1; wq(); m_sda = 1'b1; wq();
    endtask

    task automatic put_bit(input bit b);
        m_sda = b; wq(); m_scl = 1'b1; wq(); wq(); m_scl = 1'b0; wq();
    endtask

    task automatic get_bit(output bit b);
        m_sda = 1'b1; wq(); m_scl = 1'b1; wq(); b = bus_sda; wq(); m_scl = 1'b0; wq();
    endtask

    task automatic send_byte(input logic [7:0] v, output bit ack);
        bit a;
        for (int i = 7; i >= 0; i--) put_bit(v[i]);
        get_bit(a);
        ack = !a;
    endtask

    task automatic recv_byte(input bit give_ack, output logic [7:0] v);
        for (int i = 7; i >= 0; i--) begin
            bit b;
            get_bit(b);
            v[i] = b;
        end
        put_bit(!give_ack);
    endtask

    function automatic logic [7:0] sel_byte(input int blk, input bit rd, input bit csb);
        logic [1:0] bb;
        bb = 2'(blk);
        return {4'b1010, csb, bb, rd};
    endfunction

    function automatic int next_w(input int p, input bit linear);
        if (linear) return (p + 1) % 1024;
        return (p & ~15) | ((p + 1) & 15);
    endfunction

    // Poll with write select bytes until acknowledged; returns number of attempts
    task automatic poll_ready(output int tries);
        bit ack;
        tries = 0;
        do begin
            bus_start();
            send_byte(sel_byte(ref_ptr >> 8, 1'b0, 1'b1), ack);
            bus_stop();
            tries++;
        end while (!ack && tries < 20);
    endtask

    task automatic write_burst(input int addr, input int n, input string req);
        bit ack;
        int lim;
        int p;
        int taken;
        int tries;
        lim = burst8 ? 8 : 16;
        bus_start();
        send_byte(sel_byte(addr >> 8, 1'b0, 1'b1), ack);
        check(ack, req, int'(ack), 1);
        send_byte(8'(addr), ack);
        check(ack, req, int'(ack), 1);
        p = addr;
        taken = 0;
        for (int k = 0; k < n; k++) begin
            bit exp_ack;
            exp_ack = !lock && (k < lim);
            send_byte(wdat[k], ack);
            check(ack == exp_ack, req, int'(ack), int'(exp_ack));
            if (!ack) break;
            ref_mem[p] = wdat[k];
            ref_ok[p] = 1'b1;
            p = next_w(p, burst8);
            taken++;
        end
        ref_ptr = p;
        bus_stop();
        poll_ready(tries);
        if (taken > 0) begin
            check(tries > 1, "R3", tries, 2);   // R3: busy right after STOP
            check(tries < 20, "R3", tries, 2);  // R3: ready after the window
        end else begin
            check(tries == 1, "R10", tries, 1); // R10: no window without data
        end
    endtask

    task automatic read_random(input int addr, input int n, input string req, input bit silent);
        bit ack;
        logic [7:0] v;
        bus_start();
        send_byte(sel_byte(addr >> 8, 1'b0, 1'b1), ack);
        check(ack, req, int'(ack), 1);
        send_byte(8'(addr), ack);
        check(ack, req, int'(ack), 1);
        bus_start();
        send_byte(sel_byte(addr >> 8, 1'b1, 1'b1), ack);
        check(ack, req, int'(ack), 1);
        for (int k = 0; k < n; k++) begin
            int p;
            p = (addr + k) % 1024;
            recv_byte(k < n - 1, v);
            if (ref_ok[p]) check(v == ref_mem[p], req, int'(v), int'(ref_mem[p]));
        end
        ref_ptr = (addr + n) % 1024;
        if (silent) begin
            for (int k = 0; k < 9; k++) begin
                bit b;
                get_bit(b);
                check(b == 1'b1, "R9", int'(b), 1);
            end
        end
        bus_stop();
    endtask

    task automatic read_current(input int blk, input int n, input string req);
        bit ack;
        logic [7:0] v;
        int base;
        base = ((blk & 3) << 8) | (ref_ptr & 255);
        bus_start();
        send_byte(sel_byte(blk, 1'b1, 1'b1), ack);
        check(ack, req, int'(ack), 1);
        for (int k = 0; k < n; k++) begin
            int p;
            p = (base + k) % 1024;
            recv_byte(k < n - 1, v);
            if (ref_ok[p]) check(v == ref_mem[p], req, int'(v), int'(ref_mem[p]));
            else check(1'b0, req, p, -1);
        end
        ref_ptr = (base + n) % 1024;
        bus_stop();
    endtask

    task automatic fill_data();
        for (int k = 0; k < 20; k++) wdat[k] = 8'($urandom);
    endtask

    bit done = 1'b0;

    initial begin
        repeat (WATCH) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual=%0d expected=%0d", WATCH, 0);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        bit ack;
        void'($urandom(32'd4242));
        for (int i = 0; i < 1024; i++) ref_ok[i] = 1'b0;
        repeat (5) @(negedge clk);
        check(sda_oe == 1'b0, "R11", int'(sda_oe), 0);
        rst_n = 1'b1;
        wq();
        check(sda_oe == 1'b0, "R11", int'(sda_oe), 0);

        // R11: immediate acknowledge after reset
        bus_start();
        send_byte(sel_byte(0, 1'b0, 1'b1), ack);
        check(ack, "R11", int'(ack), 1);
        bus_stop();

        // R1: wrong identifier, then silence on the next byte
        bus_start();
        send_byte(8'b1011_1000, ack);
        check(!ack, "R1", int'(ack), 0);
        send_byte(8'h00, ack);
        check(!ack, "R1", int'(ack), 0);
        bus_stop();
        // R1: strap mismatch, then strap changed to match
        bus_start();
        send_byte(sel_byte(0, 1'b0, 1'b0), ack);
        check(!ack, "R1", int'(ack), 0);
        bus_stop();
        cs_pin = 1'b0;
        bus_start();
        send_byte(sel_byte(0, 1'b0, 1'b0), ack);
        check(ack, "R1", int'(ack), 1);
        bus_stop();
        cs_pin = 1'b1;

        // R4 / R2: full page writes, read back
        burst8 = 1'b0;
        fill_data();
        write_burst(0, 16, "R4");
        fill_data();
        write_burst(16, 16, "R4");
        read_random(0, 32, "R2", 1'b0);

        // R4: page wrap from 0x3F5 and refused 17th byte
        fill_data();
        write_burst(12'h3F5, 17, "R4");
        read_random(12'h3F0, 16, "R4", 1'b0);

        // R5: linear burst across a page boundary, 9th byte refused
        burst8 = 1'b1;
        fill_data();
        write_burst(12'h10E, 9, "R5");
        read_random(12'h10E, 4, "R6", 1'b0);
        read_current(1, 4, "R7");
        read_current(0, 2, "R7");
        fill_data();
        write_burst(12'h222, 1, "R5");
        read_random(12'h222, 1, "R2", 1'b1);   // R9 silence after master NACK

        // R8: sequential read across 1023 -> 0
        read_random(12'h3FE, 6, "R8", 1'b0);

        // R10: lock refuses data, array unchanged
        lock = 1'b1;
        wdat[0] = ~ref_mem[5];
        wdat[1] = ~ref_mem[6];
        write_burst(5, 2, "R10");
        lock = 1'b0;
        read_random(5, 2, "R10", 1'b0);

        // Seeded random bursts in both modes
        for (int it = 0; it < 10; it++) begin
            int addr;
            int lim;
            int n;
            burst8 = 1'($urandom);
            lim = burst8 ? 8 : 16;
            addr = int'($urandom % 1024);
            n = 1 + int'($urandom % (lim + 1));
            fill_data();
            write_burst(addr, n, burst8 ? "R5" : "R4");
            if (burst8) read_random(addr, (n < 8) ? n : 8, "R2", 1'b0);
            else        read_random(addr & ~15, 16, "R2", 1'b0);
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule